// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the byte-wide register front end of one eight-line interrupt controller. It has two addresses: address 0 is the command port and address 1 is the data port. Software uses the command port to start the initialization sequence, to issue end-of-interrupt and priority commands, and to choose what a command-port read returns. The data port carries the three initialization data words that follow an init command, and at all other times it holds the interrupt mask.

The request and in-service registers and the priority search live in a neighbouring block. This block reads their current values as inputs, places them on the read bus, and returns one-cycle strobes. One strobe tells the neighbour which in-service bits to clear. The other tells it to wipe its request and in-service state when initialization starts. The parameter `IS_SECONDARY` selects the extra check on the connection word that applies to the cascaded controller.

Top module: `irqc_cmd_port`

## Requirements
- R1: After synchronous reset the block is out of init mode and expects an init command. The mask, vector and connection bytes are 0x00, the lowest-priority pointer is 7, command-port reads return the request input, and the auto-EOI, rotate-in-auto-EOI, special-mask and poll flags are all 0.
- R2: A command-port write with bit 4 set is an init command. It is accepted only when bit 0 is set and bits 7:5 and 3:1 are clear, so only 0x11 is accepted. An accepted command enters init mode expecting the vector word, clears the mask, loads the pointer with 7, clears both auto-EOI flags, and raises `state_clr` for the single cycle after the write.
- R3: A rejected init command changes no state and raises no strobe.
- R4: In init mode, data-port writes are taken in order. The first is stored as the vector byte, the second as the connection byte, and the third is the mode word. Init mode ends once a valid mode word is taken, and the mask is not written during the sequence.
- R5: When `IS_SECONDARY` is 1, a connection word with any of bits 7:3 set is rejected. A rejected word is not stored and the sequence does not advance.
- R6: The mode word is rejected unless bit 0 is set and bits 7:5, 3 and 2 are clear. A rejected mode word keeps init mode. An accepted mode word records its bit 1 as the auto-EOI flag.
- R7: Outside init mode, a data-port write loads the mask, and a data-port read returns the mask.
- R8: A command write with bits 4:3 equal to 01 is a read-select command. When bit 1 is set, bit 0 chooses what command-port reads return: 1 selects the in-service input and 0 selects the request input. When bit 1 is clear, the selection is kept.
- R9: In a read-select command, when bit 6 is set the special-mask flag takes the value of bit 5. The poll flag takes the value of bit 2 on every read-select command.
- R10: Command bytes 0x60 to 0x67 (specific EOI) and 0xE0 to 0xE7 (specific EOI with rotate) raise `isr_clr` for line bits 2:0 for one cycle. If that line's in-service input is 0, `eoi_err` is also raised in that same cycle.
- R11: Commands 0x20 (nonspecific EOI) and 0xA0 (nonspecific EOI with rotate) raise `isr_clr` for the first set in-service line found by searching upward from pointer+1, wrapping modulo 8. When no line is in service, no bit is raised.
- R12: Commands 0xA0 and 0xE0 to 0xE7 increment the pointer modulo 8 after the line is chosen. Commands 0xC0 to 0xC7 load the pointer from bits 2:0.
- R13: Command 0x80 sets the rotate-in-auto-EOI flag and 0x00 clears it. Any other command byte with bits 4:3 equal to 00 (for example 0x21, 0x27, 0x40) changes nothing and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Current request register from the priority block |
| isr_in | input | 8 | Current in-service register from the priority block |
| rdata | output | 8 | Read data: mask (addr 1) or the selected request/in-service input (addr 0) |
| imr | output | 8 | Interrupt mask |
| vector | output | 8 | Vector byte from the first init data word |
| conn | output | 8 | Cascade connection byte |
| lowest_pri | output | 3 | Lowest-priority line pointer |
| auto_eoi | output | 1 | Auto-EOI mode flag |
| rot_aeoi | output | 1 | Rotate-in-auto-EOI flag |
| special_mask | output | 1 | Special-mask mode flag |
| poll_mode | output | 1 | Poll mode flag |
| in_init | output | 1 | Initialization sequence in progress |
| state_clr | output | 1 | One-cycle request to clear request and in-service state |
| isr_clr | output | 8 | One-cycle in-service clear bits |
| eoi_err | output | 1 | One-cycle flag: specific EOI named a line not in service |

## Verification
Most programmable state shows on its own output in the cycle after the write that set it. A wrong sequencer state shows instead as a vector, connection or mask byte landing in the wrong register on the next data write. A bad pointer shows only at the next nonspecific EOI, which clears the wrong in-service line. For that reason the random phase mixes pointer moves with nonspecific EOIs against random in-service patterns, and compares each strobe with a model one cycle after every command. A wrong read select shows immediately as the other input appearing on `rdata` at address 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES = 8;
    localparam int IDXW  = $clog2(LINES);

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [IDXW-1:0]  line_idx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_VEC  = 2'd1,
        SEQ_CONN = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    typedef struct packed {
        logic read_isr;
        logic special_mask;
        logic poll;
        logic rot_aeoi;
    } ocw_flags_t;

    localparam logic [7:0] INIT_ACCEPT   = 8'h11;
    localparam logic [7:0] INIT_REJ_MASK = 8'hEE;
    localparam logic [7:0] MODE_REJ_MASK = 8'hEC;
    localparam logic [7:0] CONN_SEC_MASK = 8'hF8;

    // One-hot of the first set bit of req, searching upward from low+1 with wrap.
    function automatic line_vec_t pick_first(line_vec_t req, line_idx_t low);
        line_vec_t res;
        logic      found;
        line_idx_t idx;
        res   = '0;
        found = 1'b0;
        for (int k = 1; k <= LINES; k++) begin
            idx = low + line_idx_t'(k);
            if (!found && req[idx]) begin
                res[idx] = 1'b1;
                found    = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
#(
    parameter bit IS_SECONDARY = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       init_go,
    output logic       in_init,
    output logic       mask_wr,
    output logic [7:0] vector,
    output logic [7:0] conn,
    output logic       auto_eoi
);

    seq_t state;
    logic conn_ok;
    logic mode_ok;

    assign init_go = cmd_wr && wdata[4] && wdata[0] && ((wdata & INIT_REJ_MASK) == 8'h00);
    assign in_init = (state != SEQ_IDLE);
    assign mask_wr = dat_wr && (state == SEQ_IDLE);

    generate
        if (IS_SECONDARY) begin : g_sec
            assign conn_ok = ((wdata & CONN_SEC_MASK) == 8'h00);
        end else begin : g_pri
            assign conn_ok = 1'b1;
        end
    endgenerate

    assign mode_ok = wdata[0] && ((wdata & MODE_REJ_MASK) == 8'h00);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            vector   <= 8'h00;
            conn     <= 8'h00;
            auto_eoi <= 1'b0;
        end else if (init_go) begin
            state    <= SEQ_VEC;
            auto_eoi <= 1'b0;
        end else if (dat_wr) begin
            unique case (state)
                SEQ_VEC: begin
                    vector <= wdata;
                    state  <= SEQ_CONN;
                end
                SEQ_CONN: begin
                    if (conn_ok) begin
                        conn  <= wdata;
                        state <= SEQ_MODE;
                    end
                end
                SEQ_MODE: begin
                    if (mode_ok) begin
                        auto_eoi <= wdata[1];
                        state    <= SEQ_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irqc_ocw_dec.sv
module irqc_ocw_dec
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] wdata,
    input  logic       init_go,
    input  line_vec_t  isr_in,
    output line_idx_t  lowest_pri,
    output ocw_flags_t flags,
    output line_vec_t  isr_clr,
    output logic       eoi_err
);

    line_idx_t sel;
    line_vec_t ns_pick;

    assign sel     = wdata[IDXW-1:0];
    assign ns_pick = pick_first(isr_in, lowest_pri);

    always_ff @(posedge clk) begin
        if (rst) begin
            lowest_pri <= line_idx_t'(LINES - 1);
            flags      <= '0;
            isr_clr    <= '0;
            eoi_err    <= 1'b0;
        end else begin
            isr_clr <= '0;
            eoi_err <= 1'b0;
            if (init_go) begin
                lowest_pri     <= line_idx_t'(LINES - 1);
                flags.rot_aeoi <= 1'b0;
            end else if (cmd_wr && wdata[3]) begin
                if (wdata[1]) flags.read_isr <= wdata[0];
                if (wdata[6]) flags.special_mask <= wdata[5];
                flags.poll <= wdata[2];
            end else if (cmd_wr) begin
                casez (wdata)
                    8'b0010_0000: isr_clr <= ns_pick;
                    8'b1010_0000: begin
                        isr_clr    <= ns_pick;
                        lowest_pri <= lowest_pri + 1'b1;
                    end
                    8'b0110_0???: begin
                        isr_clr      <= line_vec_t'(1) << sel;
                        eoi_err      <= !isr_in[sel];
                    end
                    8'b1110_0???: begin
                        isr_clr      <= line_vec_t'(1) << sel;
                        eoi_err      <= !isr_in[sel];
                        lowest_pri   <= lowest_pri + 1'b1;
                    end
                    8'b1100_0???: lowest_pri <= sel;
                    8'b1000_0000: flags.rot_aeoi <= 1'b1;
                    8'b0000_0000: flags.rot_aeoi <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_cmd_port.sv
module irqc_cmd_port
    import irqc_pkg::*;
#(
    parameter bit IS_SECONDARY = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    input  logic [7:0] irr_in,
    input  logic [7:0] isr_in,
    output logic [7:0] rdata,
    output logic [7:0] imr,
    output logic [7:0] vector,
    output logic [7:0] conn,
    output logic [2:0] lowest_pri,
    output logic       auto_eoi,
    output logic       rot_aeoi,
    output logic       special_mask,
    output logic       poll_mode,
    output logic       in_init,
    output logic       state_clr,
    output logic [7:0] isr_clr,
    output logic       eoi_err
);

    logic       cmd_wr;
    logic       dat_wr;
    logic       init_go;
    logic       mask_wr;
    ocw_flags_t flags;

    assign cmd_wr = wr_en && !addr;
    assign dat_wr = wr_en && addr;

    irqc_init_seq #(.IS_SECONDARY(IS_SECONDARY)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .dat_wr   (dat_wr),
        .wdata    (wdata),
        .init_go  (init_go),
        .in_init  (in_init),
        .mask_wr  (mask_wr),
        .vector   (vector),
        .conn     (conn),
        .auto_eoi (auto_eoi)
    );

    irqc_ocw_dec u_ocw (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr && !wdata[4]),
        .wdata      (wdata),
        .init_go    (init_go),
        .isr_in     (isr_in),
        .lowest_pri (lowest_pri),
        .flags      (flags),
        .isr_clr    (isr_clr),
        .eoi_err    (eoi_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imr       <= 8'h00;
            state_clr <= 1'b0;
        end else begin
            state_clr <= init_go;
            if (init_go)      imr <= 8'h00;
            else if (mask_wr) imr <= wdata;
        end
    end

    assign rot_aeoi     = flags.rot_aeoi;
    assign special_mask = flags.special_mask;
    assign poll_mode    = flags.poll;
    assign rdata        = addr ? imr : (flags.read_isr ? isr_in : irr_in);

endmodule

// File: rtl/irqc_cmd_port_chk.sv
module irqc_cmd_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] imr,
    input logic [7:0] vector,
    input logic [7:0] conn,
    input logic [2:0] lowest_pri,
    input logic       in_init,
    input logic       state_clr,
    input logic [7:0] isr_clr,
    input logic       eoi_err
);

    // R10
    isr_clr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_clr));

    // R10
    eoi_err_line_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_err |-> ($countones(isr_clr) == 1));

    // R2
    init_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata == 8'h11) |=>
        (in_init && imr == 8'h00 && lowest_pri == 3'd7 && state_clr));

    // R3
    init_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr && wdata[4] && wdata != 8'h11 && !in_init) |=>
        (!in_init && !state_clr));

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && !in_init) |=> (imr == $past(wdata)));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(imr) && $stable(vector) && $stable(conn) &&
                    $stable(lowest_pri) && isr_clr == 8'h00 && !eoi_err && !state_clr));

endmodule

bind irqc_cmd_port irqc_cmd_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .imr        (imr),
    .vector     (vector),
    .conn       (conn),
    .lowest_pri (lowest_pri),
    .in_init    (in_init),
    .state_clr  (state_clr),
    .isr_clr    (isr_clr),
    .eoi_err    (eoi_err)
);

// File: tb/irqc_cmd_port_tb_top.sv
`timescale 1ns/1ps
module irqc_cmd_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       addr;
    logic [7:0] wdata;
    logic [7:0] irr_in;
    logic [7:0] isr_in;

    logic [7:0] rdata, imr, vector, conn, isr_clr;
    logic [2:0] lowest_pri;
    logic       auto_eoi, rot_aeoi, special_mask, poll_mode, in_init, state_clr, eoi_err;

    logic [7:0] s_rdata, s_imr, s_vector, s_conn, s_isr_clr;
    logic [2:0] s_lowest_pri;
    logic       s_auto_eoi, s_rot_aeoi, s_special_mask, s_poll_mode, s_in_init, s_state_clr, s_eoi_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irqc_cmd_port #(.IS_SECONDARY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .irr_in(irr_in), .isr_in(isr_in), .rdata(rdata), .imr(imr),
        .vector(vector), .conn(conn), .lowest_pri(lowest_pri),
        .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .special_mask(special_mask),
        .poll_mode(poll_mode), .in_init(in_init), .state_clr(state_clr),
        .isr_clr(isr_clr), .eoi_err(eoi_err)
    );

    irqc_cmd_port #(.IS_SECONDARY(1'b1)) dut_s (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .irr_in(irr_in), .isr_in(isr_in), .rdata(s_rdata), .imr(s_imr),
        .vector(s_vector), .conn(s_conn), .lowest_pri(s_lowest_pri),
        .auto_eoi(s_auto_eoi), .rot_aeoi(s_rot_aeoi), .special_mask(s_special_mask),
        .poll_mode(s_poll_mode), .in_init(s_in_init), .state_clr(s_state_clr),
        .isr_clr(s_isr_clr), .eoi_err(s_eoi_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Write during one clock: drive at negedge, release at the next negedge.
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] model_ns(input logic [7:0] isr, input logic [2:0] ptr);
        for (int k = 1; k <= 8; k++) begin
            logic [2:0] line;
            line = ptr + 3'(k);
            if (isr[line]) return 8'(1) << line;
        end
        return 8'h00;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] m_ptr;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
        irr_in = 8'h5A; isr_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_eq("R1 in_init", in_init, 0);
        chk_eq("R1 imr", imr, 8'h00);
        chk_eq("R1 pointer", lowest_pri, 7);
        chk_eq("R1 flags", {auto_eoi, rot_aeoi, special_mask, poll_mode}, 0);
        addr = 1'b0; #0.1;
        chk_eq("R1 read selects irr", rdata, 8'h5A);

        // R7 mask load and readback
        wr(1'b1, 8'h3C);
        chk_eq("R7 imr", imr, 8'h3C);
        addr = 1'b1; #0.1;
        chk_eq("R7 data read", rdata, 8'h3C);

        // R3 rejected init commands
        wr(1'b0, 8'h10);
        wr(1'b0, 8'h13);
        wr(1'b0, 8'h19);
        wr(1'b0, 8'h31);
        wr(1'b0, 8'h15);
        chk_eq("R3 not in init", in_init, 0);
        chk_eq("R3 imr kept", imr, 8'h3C);

        // R12 set lowest, R13 rotate-aeoi set
        wr(1'b0, 8'hC2);
        chk_eq("R12 set pointer", lowest_pri, 2);
        wr(1'b0, 8'h80);
        chk_eq("R13 rot set", rot_aeoi, 1);

        // R2 accepted init
        wr(1'b0, 8'h11);
        chk_eq("R2 in_init", in_init, 1);
        chk_eq("R2 imr cleared", imr, 8'h00);
        chk_eq("R2 pointer 7", lowest_pri, 7);
        chk_eq("R2 rot cleared", rot_aeoi, 0);
        chk_eq("R2 state_clr", state_clr, 1);
        @(negedge clk);
        chk_eq("R2 state_clr one cycle", state_clr, 0);

        // R4 sequence, R5 secondary connection check, R6 mode word check
        wr(1'b1, 8'h48);
        chk_eq("R4 vector", vector, 8'h48);
        chk_eq("R4 vector sec", s_vector, 8'h48);
        chk_eq("R4 imr untouched", imr, 8'h00);
        wr(1'b1, 8'h0A);
        chk_eq("R4 conn primary", conn, 8'h0A);
        chk_eq("R5 conn secondary rejected", s_conn, 8'h00);
        wr(1'b1, 8'h02);
        chk_eq("R5 conn secondary", s_conn, 8'h02);
        chk_eq("R6 bad mode keeps init", in_init, 1);
        wr(1'b1, 8'h0B);
        wr(1'b1, 8'h05);
        wr(1'b1, 8'h23);
        chk_eq("R6 rejected modes keep init", in_init, 1);
        chk_eq("R6 rejected no aeoi", auto_eoi, 0);
        wr(1'b1, 8'h13);
        chk_eq("R6 init done", in_init, 0);
        chk_eq("R6 init done sec", s_in_init, 0);
        chk_eq("R6 aeoi recorded", auto_eoi, 1);
        chk_eq("R4 imr after sequence", imr, 8'h00);

        // R8 read select
        wr(1'b0, 8'h0B);
        addr = 1'b0; #0.1;
        chk_eq("R8 isr selected", rdata, 8'hA5);
        wr(1'b0, 8'h08);
        addr = 1'b0; #0.1;
        chk_eq("R8 selection kept", rdata, 8'hA5);
        wr(1'b0, 8'h0A);
        addr = 1'b0; #0.1;
        chk_eq("R8 irr selected", rdata, 8'h5A);

        // R9 special mask and poll
        wr(1'b0, 8'h6C);
        chk_eq("R9 smm set", special_mask, 1);
        chk_eq("R9 poll set", poll_mode, 1);
        wr(1'b0, 8'h28);
        chk_eq("R9 smm kept", special_mask, 1);
        chk_eq("R9 poll cleared", poll_mode, 0);
        wr(1'b0, 8'h48);
        chk_eq("R9 smm cleared", special_mask, 0);

        // R10 specific EOI
        isr_in = 8'h10;
        wr(1'b0, 8'h64);
        chk_eq("R10 clear line 4", isr_clr, 8'h10);
        chk_eq("R10 no error", eoi_err, 0);
        wr(1'b0, 8'h63);
        chk_eq("R10 clear line 3", isr_clr, 8'h08);
        chk_eq("R10 error", eoi_err, 1);
        @(negedge clk);
        chk_eq("R10 strobes one cycle", {isr_clr, eoi_err}, 0);

        // R11 nonspecific EOI
        isr_in = 8'h28;
        wr(1'b0, 8'h20);
        chk_eq("R11 ptr7 pick", isr_clr, 8'h08);
        wr(1'b0, 8'hC3);
        wr(1'b0, 8'h20);
        chk_eq("R11 ptr3 pick", isr_clr, 8'h20);
        isr_in = 8'h00;
        wr(1'b0, 8'h20);
        chk_eq("R11 empty", isr_clr, 8'h00);
        isr_in = 8'h09;
        wr(1'b0, 8'hA0);
        chk_eq("R11 rotate pick wraps", isr_clr, 8'h01);
        chk_eq("R12 rotate increments", lowest_pri, 4);
        wr(1'b0, 8'hC7);
        wr(1'b0, 8'hE2);
        chk_eq("R12 rotate wraps", lowest_pri, 0);
        chk_eq("R10 specific rotate clear", isr_clr, 8'h04);

        // R13 rotate-aeoi and ignored codes
        wr(1'b0, 8'h80);
        chk_eq("R13 rot set", rot_aeoi, 1);
        wr(1'b0, 8'h00);
        chk_eq("R13 rot clear", rot_aeoi, 0);
        isr_in = 8'hFF;
        wr(1'b0, 8'h21);
        chk_eq("R13 0x21 ignored", {isr_clr, eoi_err}, 0);
        wr(1'b0, 8'h40);
        chk_eq("R13 0x40 ignored", {isr_clr, lowest_pri, rot_aeoi}, 0);
        wr(1'b0, 8'h27);
        chk_eq("R13 0x27 ignored", {isr_clr, lowest_pri}, 0);

        // R2 second init clears auto-EOI
        wr(1'b0, 8'h11);
        chk_eq("R2 aeoi cleared", auto_eoi, 0);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        chk_eq("R4 second init done", in_init, 0);

        // Random phase: R7 R10 R11 R12 against model
        m_ptr = 3'd7;
        for (int it = 0; it < 400; it++) begin
            int kind;
            logic [7:0] cmd, exp_clr;
            logic [2:0] ln;
            logic       exp_err;
            kind   = int'($urandom % 6);
            ln     = 3'($urandom);
            isr_in = 8'($urandom);
            exp_clr = 8'h00;
            exp_err = 1'b0;
            case (kind)
                0: begin cmd = 8'h20; exp_clr = model_ns(isr_in, m_ptr); end
                1: begin cmd = 8'h60 | 8'(ln); exp_clr = 8'(1) << ln; exp_err = !isr_in[ln]; end
                2: begin cmd = 8'hA0; exp_clr = model_ns(isr_in, m_ptr); m_ptr = m_ptr + 3'd1; end
                3: begin cmd = 8'hE0 | 8'(ln); exp_clr = 8'(1) << ln; exp_err = !isr_in[ln]; m_ptr = m_ptr + 3'd1; end
                4: begin cmd = 8'hC0 | 8'(ln); m_ptr = ln; end
                default: cmd = 8'($urandom);
            endcase
            if (kind == 5) begin
                wr(1'b1, cmd);
                chk_eq("R7 random mask", imr, cmd);
            end else begin
                wr(1'b0, cmd);
                chk_eq("R11 R10 random clear", isr_clr, exp_clr);
                chk_eq("R10 random error", eoi_err, exp_err);
                chk_eq("R12 random pointer", lowest_pri, m_ptr);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule